// File: doc/BRIEF.md
# Timed Output Word Sequencer

This block plays a short, locally stored list of output states onto a 16-bit parallel register. Each entry pairs a word, which drives all 16 channel bits at once, with a state length counted in whole clock cycles. A reload counter times the active state. At each reload the next word goes out, and one cycle later the length of the entry after it is copied into a shadow register. That shadowed length becomes active only at the following reload.

Entries are written through a plain write port: address, word and length. A last-index input sets the list length, and a mode input selects one-shot or endless circular playback. Start launches playback from entry 0, and stop abandons it. Suspend blanks the outputs and freezes the timer, after which playback resumes inside the same entry. Because of the fetch one cycle after each reload, no state may be shorter than two cycles. Shorter lengths are raised to two when written, and a sticky error flag records this.

Top module: `tws_sequencer`

## Requirements
- R1: After reset, out_word is 0, busy is 0, done is 0 and dur_err is 0.
- R2: A start pulse while idle (and stop low) makes busy 1 and out_word equal to entry 0's word from the next cycle on.
- R3: Entries play in index order 0..cfg_last. Each entry's word stays on out_word, with all bits changing in the same cycle, for exactly its stored length in cycles, and the next word follows with no gap.
- R4: An entry's length is captured one timer cycle after the reload that starts the entry before it. A later write to that entry's length, made before that entry starts, does not change the entry's length in the current pass. A write made before the capture does take effect.
- R5: A written length below 2 is stored as 2, and dur_err goes to 1 on the next cycle. dur_err stays at 1 until reset.
- R6: In one-shot mode (cfg_circular=0), when the last entry's length has elapsed, out_word becomes 0 and busy becomes 0, and done is 1 for exactly that one cycle.
- R7: In circular mode (cfg_circular=1), entry 0 follows the last entry directly, busy stays 1 and done stays 0.
- R8: Stop while busy makes out_word 0 and busy 0 from the next cycle, with no done pulse. Stop takes priority over a simultaneous start.
- R9: Each cycle in which suspend was high at the previous edge shows out_word 0 and does not advance the timer. After release, the same entry continues, so its visible cycles still total its length.
- R10: Start while busy has no effect on the word sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one pattern entry |
| wr_addr | input | 3 | Entry index to write |
| wr_word | input | 16 | Output word of the entry |
| wr_dur | input | 16 | Entry length in cycles |
| cfg_last | input | 3 | Index of the final entry |
| cfg_circular | input | 1 | 1 = repeat endlessly, 0 = play once |
| start | input | 1 | Begin playback from entry 0 |
| stop | input | 1 | Abort playback |
| suspend | input | 1 | Blank outputs and freeze timing |
| out_word | output | 16 | Parallel channel output |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle pulse at the end of a one-shot pass |
| dur_err | output | 1 | Sticky flag: a length below 2 was written |

## Verification
A bench model predicts out_word, busy and done on every cycle. It is driven by seeded random patterns with mixed lengths, including the clamped values 0 and 1, together with random start, stop and suspend activity in both modes. The random runs show whether state lengths and ordering hold under interruption. Directed cases check behaviour at the edges. Back-to-back two-cycle states expose an off-by-one in the reload compare. A write to an entry's length just before and just after its capture separates shadowed timing from a live memory read. Suspend held across a reload shows that the frozen timer keeps the entry's visible cycle count.

// File: rtl/tws_pkg.sv
// Shared types for the timed output word sequencer.
package tws_pkg;
    // Playback phase of the sequencer.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } tws_phase_e;
endpackage

// File: rtl/tws_pattern_mem.sv
// Pattern store: DEPTH entries of {word, length}. Lengths below MIN_DUR are
// raised to MIN_DUR on write and set a sticky error flag.
// Assumes: reads are combinational; a write is visible from the next cycle.
module tws_pattern_mem #(
    parameter int WORD_W  = 16,
    parameter int DUR_W   = 16,
    parameter int DEPTH   = 8,
    parameter int MIN_DUR = 2,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DUR_W-1:0]  wr_dur,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic [DUR_W-1:0]  rd_dur,
    output logic              dur_err
);
    localparam logic [DUR_W-1:0] MIN_V = DUR_W'(MIN_DUR);

    logic [WORD_W-1:0] word_mem [DEPTH];
    logic [DUR_W-1:0]  dur_mem  [DEPTH];
    logic              too_short;

    // Flag a length that needs clamping.
    assign too_short = wr_dur < MIN_V;

    // Store entries, clamping short lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                word_mem[i] <= '0;
                dur_mem[i]  <= MIN_V;
            end
        end else if (wr_en) begin
            word_mem[wr_addr] <= wr_word;
            dur_mem[wr_addr]  <= too_short ? MIN_V : wr_dur;
        end
    end

    // Sticky record of any clamped write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  dur_err <= 1'b0;
        else if (wr_en && too_short) dur_err <= 1'b1;
    end

    // Combinational read port.
    assign rd_word = word_mem[rd_addr];
    assign rd_dur  = dur_mem[rd_addr];

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dur_err |=> dur_err);
    assert_clamp_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dur < MIN_V) |=> dur_err);
endmodule

// File: rtl/tws_reload_timer.sv
// Reload timer: counts from 0 to the active length minus one, then reloads.
// At a reload the shadowed length becomes active. One running cycle after a
// reload, the next length is copied into the shadow register.
// Assumes: every length is at least MIN_DUR (>= 2), and load only while not running.
module tws_reload_timer #(
    parameter int DUR_W   = 16,
    parameter int MIN_DUR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DUR_W-1:0] load_dur,
    input  logic             run,
    input  logic             freeze,
    input  logic [DUR_W-1:0] fetch_dur,
    output logic             reload
);
    logic [DUR_W-1:0] cnt_q;
    logic [DUR_W-1:0] active_q;
    logic [DUR_W-1:0] shadow_q;
    logic             tick;

    // Timer advances only while running and not frozen.
    assign tick   = run && !freeze;
    assign reload = tick && (cnt_q == active_q - DUR_W'(1));

    // Counter and active length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= DUR_W'(MIN_DUR);
        end else if (load) begin
            cnt_q    <= '0;
            active_q <= load_dur;
        end else if (reload) begin
            cnt_q    <= '0;
            active_q <= shadow_q;
        end else if (tick) begin
            cnt_q    <= cnt_q + DUR_W'(1);
        end
    end

    // Shadow fetch one running cycle after each reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                             shadow_q <= DUR_W'(MIN_DUR);
        else if (tick && cnt_q == '0 && !load)  shadow_q <= fetch_dur;
    end

    assert_min_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> active_q >= DUR_W'(MIN_DUR));
    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && freeze) |=> $stable(cnt_q));
endmodule

// File: rtl/tws_sequencer.sv
// Timed output word sequencer top. It plays entries 0..cfg_last of the pattern
// store onto out_word, one-shot or circular, with start/stop/suspend control.
// Assumes: cfg_last and cfg_circular stay stable during playback.
module tws_sequencer #(
    parameter int WORD_W  = 16,
    parameter int DUR_W   = 16,
    parameter int DEPTH   = 8,
    parameter int MIN_DUR = 2,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DUR_W-1:0]  wr_dur,
    input  logic [AW-1:0]     cfg_last,
    input  logic              cfg_circular,
    input  logic              start,
    input  logic              stop,
    input  logic              suspend,
    output logic [WORD_W-1:0] out_word,
    output logic              busy,
    output logic              done,
    output logic              dur_err
);
    import tws_pkg::*;

    tws_phase_e        phase_q;
    logic [AW-1:0]     idx_q;
    logic [AW-1:0]     nidx;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] rd_word;
    logic [DUR_W-1:0]  rd_dur;
    logic              done_q;
    logic              susp_q;
    logic              start_go;
    logic              stop_go;
    logic              tmr_run;
    logic              reload;
    logic              at_last;

    // Next index with wrap at the final entry.
    assign at_last  = (idx_q == cfg_last) || (idx_q == AW'(DEPTH - 1));
    assign nidx     = at_last ? '0 : idx_q + AW'(1);
    assign rd_addr  = (phase_q == PH_RUN) ? nidx : '0;

    // Control decode.
    assign start_go = (phase_q == PH_IDLE) && start && !stop;
    assign stop_go  = (phase_q == PH_RUN) && stop;
    assign tmr_run  = (phase_q == PH_RUN) && !stop;

    tws_pattern_mem #(
        .WORD_W(WORD_W), .DUR_W(DUR_W), .DEPTH(DEPTH), .MIN_DUR(MIN_DUR)
    ) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word), .wr_dur(wr_dur),
        .rd_addr(rd_addr), .rd_word(rd_word), .rd_dur(rd_dur),
        .dur_err(dur_err)
    );

    tws_reload_timer #(
        .DUR_W(DUR_W), .MIN_DUR(MIN_DUR)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(start_go), .load_dur(rd_dur),
        .run(tmr_run), .freeze(susp_q),
        .fetch_dur(rd_dur), .reload(reload)
    );

    // Playback state, output word and end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            word_q  <= '0;
            done_q  <= 1'b0;
            susp_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            susp_q <= suspend;
            if (start_go) begin
                phase_q <= PH_RUN;
                idx_q   <= '0;
                word_q  <= rd_word;
            end else if (stop_go) begin
                phase_q <= PH_IDLE;
                word_q  <= '0;
            end else if (reload) begin
                if (idx_q == cfg_last && !cfg_circular) begin
                    phase_q <= PH_IDLE;
                    word_q  <= '0;
                    done_q  <= 1'b1;
                end else begin
                    idx_q  <= nidx;
                    word_q <= rd_word;
                end
            end
        end
    end

    // Outputs blanked during suspend.
    assign out_word = susp_q ? '0 : word_q;
    assign busy     = (phase_q == PH_RUN);
    assign done     = done_q;

    assert_done_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> out_word == '0);
    assert_susp_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(suspend) |-> out_word == '0);
    assert_circ_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && cfg_circular && !stop) |=> busy);
    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop) |=> (!busy && !done));
endmodule

// File: tb/tws_sequencer_test.sv
module tws_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_word = '0;
    logic [15:0] wr_dur = '0;
    logic [2:0]  cfg_last = '0;
    logic        cfg_circular = 1'b0;
    logic        start = 1'b0, stop = 1'b0, suspend = 1'b0;
    logic [15:0] out_word;
    logic        busy, done, dur_err;

    int errors = 0, checks = 0;
    bit finished = 0;

    // Bench model state
    logic [15:0] mw [8];
    int          md [8];
    bit          m_busy, m_done, m_susp, m_err, track;
    int          m_idx, m_left;
    logic [15:0] m_word;

    always #10 clk = ~clk;

    tws_sequencer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_word(wr_word), .wr_dur(wr_dur), .cfg_last(cfg_last),
        .cfg_circular(cfg_circular), .start(start), .stop(stop),
        .suspend(suspend), .out_word(out_word), .busy(busy), .done(done),
        .dur_err(dur_err)
    );

    function automatic int clampd(input int d);
        return (d < 2) ? 2 : d;
    endfunction

    // One clock edge of the requirement model.
    task automatic model_edge();
        m_done = 0;
        if (!m_busy) begin
            if (start && !stop) begin
                m_busy = 1; m_idx = 0; m_left = md[0]; m_word = mw[0];
            end
        end else if (stop) begin
            m_busy = 0; m_word = '0;
        end else if (!m_susp) begin
            if (m_left == 1) begin
                if (m_idx == int'(cfg_last) && !cfg_circular) begin
                    m_busy = 0; m_word = '0; m_done = 1;
                end else begin
                    m_idx = (m_idx == int'(cfg_last) || m_idx == 7) ? 0 : m_idx + 1;
                    m_left = md[m_idx]; m_word = mw[m_idx];
                end
            end else m_left--;
        end
        m_susp = suspend;
        if (wr_en) begin
            if (wr_dur < 2) m_err = 1;
            if (track) begin mw[wr_addr] = wr_word; md[wr_addr] = clampd(int'(wr_dur)); end
        end
    endtask

    task automatic check(input string tag, input bit ok, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Advance one cycle and compare all outputs against the model.
    task automatic tick(input string tag);
        logic [15:0] ew;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        ew = (m_busy && !m_susp) ? m_word : 16'h0;
        check(tag, out_word == ew, "out_word", out_word, ew);
        check(tag, {busy, done, dur_err} == {m_busy, m_done, m_err},
              "busy/done/err", {busy, done, dur_err}, {m_busy, m_done, m_err});
    endtask

    task automatic wr(input int a, input logic [15:0] w, input int d, input string tag);
        wr_en = 1; wr_addr = 3'(a); wr_word = w; wr_dur = 16'(d);
        tick(tag);
        wr_en = 0;
    endtask

    task automatic pulse_start(input string tag);
        start = 1; tick(tag); start = 0;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        track = 1;
        for (int i = 0; i < 8; i++) begin mw[i] = '0; md[i] = 2; end
        m_busy = 0; m_done = 0; m_susp = 0; m_err = 0; m_idx = 0; m_left = 0; m_word = '0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1", out_word == 0 && !busy && !done && !dur_err, "reset outputs",
              {out_word, busy, done, dur_err}, 0);

        // R2, R3, R6: one-shot with distinct words and lengths
        wr(0, 16'hA5A5, 3, "R3"); wr(1, 16'h5A5A, 2, "R3"); wr(2, 16'hFFFF, 4, "R3");
        cfg_last = 2; cfg_circular = 0;
        pulse_start("R2");
        check("R2", busy && out_word == 16'hA5A5, "first word", out_word, 16'hA5A5);
        run(10, "R3");
        run(3, "R6");

        // R5: clamped lengths, back-to-back two-cycle states
        wr(0, 16'h0001, 0, "R5");
        check("R5", dur_err == 1, "dur_err after short write", dur_err, 1);
        wr(1, 16'h0002, 1, "R5"); wr(2, 16'h0004, 2, "R5");
        pulse_start("R5"); run(8, "R5");
        check("R5", dur_err == 1, "dur_err sticky", dur_err, 1);

        // R7: circular wrap
        wr(0, 16'h1111, 3, "R7"); wr(1, 16'h2222, 2, "R7");
        cfg_last = 1; cfg_circular = 1;
        pulse_start("R7"); run(16, "R7");
        // R10: start while busy
        start = 1; run(3, "R10"); start = 0; run(4, "R10");
        // R8: stop, and stop beats start
        stop = 1; tick("R8");
        check("R8", !busy && out_word == 0 && !done, "stopped", {busy, out_word}, 0);
        start = 1; tick("R8"); start = 0; stop = 0;
        check("R8", !busy, "stop over start", busy, 0);

        // R9: suspend across a reload
        cfg_circular = 0;
        wr(0, 16'hC3C3, 4, "R9"); wr(1, 16'h3C3C, 3, "R9");
        pulse_start("R9"); run(2, "R9");
        suspend = 1; run(2, "R9");
        check("R9", out_word == 0 && busy, "blanked", out_word, 0);
        run(3, "R9"); suspend = 0; run(10, "R9");

        // R4: capture timing of the shadow length
        wr(0, 16'h00AA, 5, "R4"); wr(1, 16'h00BB, 3, "R4"); wr(2, 16'h00CC, 3, "R4");
        cfg_last = 2;
        pulse_start("R4");
        tick("R4");                        // entry 1 length captured here
        track = 0; wr(1, 16'h00BB, 7, "R4");  // too late: entry 1 keeps 3
        track = 1; wr(2, 16'h00CC, 6, "R4");  // before capture: entry 2 gets 6
        run(14, "R4");
        wr(1, 16'h00BB, 3, "R4");

        // R3: seeded random patterns with random control
        for (int t = 0; t < 10; t++) begin
            for (int a = 0; a < 8; a++)
                wr(a, 16'($urandom), int'($urandom_range(0, 6)), "R3");
            cfg_last = 3'($urandom_range(0, 7));
            cfg_circular = 1'($urandom_range(0, 1));
            pulse_start("R3");
            for (int c = 0; c < 200; c++) begin
                stop = ($urandom_range(0, 79) == 0);
                start = ($urandom_range(0, 19) == 0);
                if ($urandom_range(0, 14) == 0) suspend = ~suspend;
                tick("R3");
            end
            start = 0; suspend = 0; stop = 1; tick("R8"); stop = 0; tick("R3");
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule